// File: doc/BRIEF.md
# PLL Configuration Register with Lock Tracking

This block holds the 32-bit configuration word of one phase-locked loop. A write port loads the word, and a read port returns the stored value. The block takes the divider fields out of the word and reports whether the loop counts as locked. Lock is modelled as immediate. Writing the power-down bit unlocks the loop and sets a sticky lock-lost flag. Writing with power-down clear locks the loop again. The lost flag stays set until a one is written to its bit position.

From a reference frequency input, the block computes an output frequency code. The code is the reference times the feedback divider, divided by the product of the input divider and the two output dividers. The code is zero while the loop is unlocked. A divisor product of zero gives a zero result and raises an error flag instead of an undefined quotient. A new result is registered one cycle after a configuration write, or one cycle after the reference input changes. A one-cycle valid strobe marks each new result.

The asynchronous reset `rst_n` is released through a two-stage synchroniser inside the block.

Top module: `pll_cfg_reg`

## Requirements
- R1: Reset and first result.
  - While reset is held and after it is released, `rd_data` equals RESET_WORD (default 0x80222101), `locked` is 1 and `lock_lost` is 0.
  - The third rising edge after `rst_n` rises is the first edge that acts. On that edge, `freq_valid` pulses with the result for the reset word. With a 25 MHz reference this result is 850000000.
- R2: Field positions in the word:
  - feedback divider: bits 27:16, on `fb_div`
  - second output divider: bits 15:13, on `out_div2`
  - first output divider: bits 10:8, on `out_div1`
  - input divider: bits 5:0, on `in_div`
  - power-down: bit 12, on `pwr_down`
  - lock indicator: bit 31, on `locked`
  - sticky lock-lost flag: bit 30, on `lock_lost`
- R3: A write with bit 12 set stores bit 31 as 0 and bit 30 as 1, whatever the written values of those two bits.
- R4: A write with bit 12 clear stores bit 31 as 1. If bit 30 is written as 1, the stored bit 30 is cleared. If bit 30 is written as 0, the stored bit 30 keeps its previous value.
- R5: All other bits are stored exactly as written. The stored word appears on `rd_data` from the cycle after the write. With `wr_en` low, the stored word never changes.
- R6: While locked, with a nonzero divisor product, `freq_out` = floor(ref_freq × feedback / (input × out1 × out2)).
- R7: When the lock indicator is 0, the computed `freq_out` is 0.
- R8: When input × out1 × out2 is 0, the computed `freq_out` is 0 and `div_err` is 1. Otherwise `div_err` is 0.
- R9: Result timing.
  - `freq_valid` is 1 on the cycle after a write. It is also 1 on the cycle after an edge at which `ref_freq` differs from its value at the previous edge.
  - The new result uses the configuration after the write and the reference value present at the strobe edge.
  - On other cycles, `freq_valid` is 0 and `freq_out` and `div_err` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Word to write |
| rd_data | output | 32 | Stored configuration word |
| ref_freq | input | REF_W (32) | Reference frequency code |
| fb_div | output | 12 | Feedback divider field |
| out_div2 | output | 3 | Second output divider field |
| out_div1 | output | 3 | First output divider field |
| in_div | output | 6 | Input divider field |
| pwr_down | output | 1 | Power-down bit of the stored word |
| locked | output | 1 | Lock indicator |
| lock_lost | output | 1 | Sticky lock-lost flag |
| freq_out | output | REF_W+12 (44) | Output frequency code |
| freq_valid | output | 1 | One-cycle strobe marking a new result |
| div_err | output | 1 | Divisor product was zero for the current result |

## Verification
The assertions check the following on every cycle:
- the lock-bit update rules on each write: power-down, write-one-to-clear and the sticky hold;
- a stored word that stays put with no write;
- a lock indicator that is always the inverse of power-down;
- a zero result whenever the divider error is raised or the previous configuration was unlocked;
- a frequency output that holds between strobes.

Only the bench's scenarios show the arithmetic and its timing against an independent model:
- the exact quotient for several divider mixes, for the widest feedback value and for changed reference values;
- the reset-release latency;
- the strobe that follows a reference change.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int WORD_W   = 32;

  localparam int FB_LSB   = 16;
  localparam int FB_W     = 12;
  localparam int OD2_LSB  = 13;
  localparam int OD2_W    = 3;
  localparam int OD1_LSB  = 8;
  localparam int OD1_W    = 3;
  localparam int IN_LSB   = 0;
  localparam int IN_W     = 6;

  localparam int PD_BIT   = 12;
  localparam int LOCK_BIT = 31;
  localparam int LOST_BIT = 30;

  localparam int DEN_W    = IN_W + OD1_W + OD2_W;

  typedef struct packed {
    logic [FB_W-1:0]  fb;
    logic [OD2_W-1:0] od2;
    logic [OD1_W-1:0] od1;
    logic [IN_W-1:0]  indiv;
    logic             pd;
    logic             lock;
    logic             lost;
  } pll_fields_t;

endpackage

// File: rtl/pll_cfg_store.sv
module pll_cfg_store
  import pll_cfg_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = 32'h8022_2101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] cfg,
  output logic              cfg_upd
);

  logic [WORD_W-1:0] cfg_nxt;

  // Lock bookkeeping applied to the incoming word
  always_comb begin
    cfg_nxt = wr_data;
    if (wr_data[PD_BIT]) begin
      cfg_nxt[LOCK_BIT] = 1'b0;
      cfg_nxt[LOST_BIT] = 1'b1;
    end else begin
      cfg_nxt[LOCK_BIT] = 1'b1;
      cfg_nxt[LOST_BIT] = wr_data[LOST_BIT] ? 1'b0 : cfg[LOST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= RESET_WORD;
      cfg_upd <= 1'b1;
    end else begin
      cfg_upd <= wr_en;
      if (wr_en) begin
        cfg <= cfg_nxt;
      end
    end
  end

endmodule

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_cfg_pkg::*;
(
  input  logic [WORD_W-1:0] cfg,
  output pll_fields_t       fields
);

  always_comb begin
    fields.fb    = cfg[FB_LSB  +: FB_W];
    fields.od2   = cfg[OD2_LSB +: OD2_W];
    fields.od1   = cfg[OD1_LSB +: OD1_W];
    fields.indiv = cfg[IN_LSB  +: IN_W];
    fields.pd    = cfg[PD_BIT];
    fields.lock  = cfg[LOCK_BIT];
    fields.lost  = cfg[LOST_BIT];
  end

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_cfg_pkg::*;
#(
  parameter int REF_W = 32,
  localparam int FREQ_W = REF_W + FB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_upd,
  input  pll_fields_t       fields,
  input  logic [REF_W-1:0]  ref_freq,
  output logic [FREQ_W-1:0] freq_out,
  output logic              freq_valid,
  output logic              div_err
);

  logic [REF_W-1:0]  ref_q;
  logic              trig;
  logic [DEN_W-1:0]  den;
  logic [DEN_W-1:0]  den_safe;
  logic              den_zero;
  logic [FREQ_W-1:0] num;
  logic [FREQ_W-1:0] quot;

  always_comb begin
    trig     = cfg_upd || (ref_freq != ref_q);
    den      = DEN_W'(fields.indiv) * DEN_W'(fields.od1) * DEN_W'(fields.od2);
    den_zero = (den == '0);
    den_safe = den_zero ? DEN_W'(1) : den;
    num      = FREQ_W'(ref_freq) * FREQ_W'(fields.fb);
    if (!fields.lock || den_zero) begin
      quot = '0;
    end else begin
      quot = num / FREQ_W'(den_safe);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      freq_out   <= '0;
      freq_valid <= 1'b0;
      div_err    <= 1'b0;
    end else begin
      ref_q      <= ref_freq;
      freq_valid <= trig;
      if (trig) begin
        freq_out <= quot;
        div_err  <= den_zero;
      end
    end
  end

endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_cfg_pkg::*;
#(
  parameter int REF_W = 32,
  parameter logic [31:0] RESET_WORD = 32'h8022_2101,
  localparam int FREQ_W = REF_W + FB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [REF_W-1:0]  ref_freq,
  output logic [FB_W-1:0]   fb_div,
  output logic [OD2_W-1:0]  out_div2,
  output logic [OD1_W-1:0]  out_div1,
  output logic [IN_W-1:0]   in_div,
  output logic              pwr_down,
  output logic              locked,
  output logic              lock_lost,
  output logic [FREQ_W-1:0] freq_out,
  output logic              freq_valid,
  output logic              div_err
);

  logic        rst_meta_n;
  logic        rst_sync_n;
  logic [31:0] cfg;
  logic        cfg_upd;
  pll_fields_t fields;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pll_cfg_store #(.RESET_WORD(RESET_WORD)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .cfg_upd (cfg_upd)
  );

  pll_field_decode u_decode (
    .cfg    (cfg),
    .fields (fields)
  );

  pll_freq_calc #(.REF_W(REF_W)) u_calc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_upd    (cfg_upd),
    .fields     (fields),
    .ref_freq   (ref_freq),
    .freq_out   (freq_out),
    .freq_valid (freq_valid),
    .div_err    (div_err)
  );

  assign rd_data   = cfg;
  assign fb_div    = fields.fb;
  assign out_div2  = fields.od2;
  assign out_div1  = fields.od1;
  assign in_div    = fields.indiv;
  assign pwr_down  = fields.pd;
  assign locked    = fields.lock;
  assign lock_lost = fields.lost;

endmodule

// File: rtl/pll_cfg_checker.sv
module pll_cfg_checker #(
  parameter int FREQ_W = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_data,
  input logic              pwr_down,
  input logic              locked,
  input logic              lock_lost,
  input logic [FREQ_W-1:0] freq_out,
  input logic              freq_valid,
  input logic              div_err
);

  AST_PD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12]) |=> (!locked && lock_lost));                             // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[12] && wr_data[30]) |=> (locked && !lock_lost));             // R4

  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[12] && !wr_data[30]) |=> (lock_lost == $past(lock_lost)));   // R4

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));                                                   // R5

  AST_LOCK_VS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    locked == !pwr_down);                                                           // R2

  AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && !$past(locked)) |-> (freq_out == '0));                           // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> (freq_out == '0));                                                  // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_valid |-> ($stable(freq_out) && $stable(div_err)));                       // R9

endmodule

bind pll_cfg_reg pll_cfg_checker #(.FREQ_W(FREQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .pwr_down   (pwr_down),
  .locked     (locked),
  .lock_lost  (lock_lost),
  .freq_out   (freq_out),
  .freq_valid (freq_valid),
  .div_err    (div_err)
);

// File: tb/pll_cfg_reg_bench.sv
module pll_cfg_reg_bench;

  localparam int REF_W  = 32;
  localparam int FREQ_W = REF_W + 12;
  localparam logic [31:0] RST_WORD = 32'h8022_2101;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [31:0]       wr_data;
  logic [31:0]       rd_data;
  logic [REF_W-1:0]  ref_freq;
  logic [11:0]       fb_div;
  logic [2:0]        out_div2;
  logic [2:0]        out_div1;
  logic [5:0]        in_div;
  logic              pwr_down;
  logic              locked;
  logic              lock_lost;
  logic [FREQ_W-1:0] freq_out;
  logic              freq_valid;
  logic              div_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  pll_cfg_reg #(.REF_W(REF_W), .RESET_WORD(RST_WORD)) u_pll_cfg_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ref_freq(ref_freq), .fb_div(fb_div), .out_div2(out_div2), .out_div1(out_div1),
    .in_div(in_div), .pwr_down(pwr_down), .locked(locked), .lock_lost(lock_lost),
    .freq_out(freq_out), .freq_valid(freq_valid), .div_err(div_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected result from the stated formula
  function automatic longint calc_freq(logic [31:0] w, longint r);
    longint fb  = longint'(w[27:16]);
    longint den = longint'(w[5:0]) * longint'(w[10:8]) * longint'(w[15:13]);
    if (!w[31] || den == 0) return 0;
    return (r * fb) / den;
  endfunction

  function automatic logic [31:0] apply_write(logic [31:0] old, logic [31:0] d);
    logic [31:0] n = d;
    if (d[12]) begin n[31] = 1'b0; n[30] = 1'b1; end
    else begin n[31] = 1'b1; n[30] = d[30] ? 1'b0 : old[30]; end
    return n;
  endfunction

  // Behavioural reference model, stepped on each rising edge
  int          m_rcnt;
  logic [31:0] m_cfg;
  bit          m_upd;
  longint      m_refq;
  longint      m_freq;
  bit          m_valid;
  bit          m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || m_rcnt < 2) begin
      m_rcnt  = rst_n ? m_rcnt + 1 : 0;
      m_cfg   = RST_WORD;
      m_upd   = 1'b1;
      m_refq  = 0;
      m_freq  = 0;
      m_valid = 1'b0;
      m_err   = 1'b0;
    end else begin
      if (m_upd || longint'(ref_freq) != m_refq) begin
        m_valid = 1'b1;
        m_freq  = calc_freq(m_cfg, longint'(ref_freq));
        m_err   = (m_cfg[5:0] == 0) || (m_cfg[10:8] == 0) || (m_cfg[15:13] == 0);
      end else begin
        m_valid = 1'b0;
      end
      m_refq = longint'(ref_freq);
      m_upd  = wr_en;
      if (wr_en) m_cfg = apply_write(m_cfg, wr_data);
    end
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R5 rd_data", longint'(rd_data), longint'(m_cfg));
      check("R6 freq_out", longint'(freq_out), m_freq);
      check("R9 freq_valid", longint'(freq_valid), longint'(m_valid));
      check("R8 div_err", longint'(div_err), longint'(m_err));
    end
  end

  task automatic write_word(logic [31:0] d);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    ref_freq = 32'd25_000_000;
    repeat (3) @(negedge clk);
    check("R1 reset word", longint'(rd_data), longint'(RST_WORD));
    check("R1 locked at reset", longint'(locked), 1);
    check("R1 lost clear at reset", longint'(lock_lost), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 no strobe during release", longint'(freq_valid), 0);
    @(negedge clk);
    check("R1 first strobe", longint'(freq_valid), 1);
    check("R1 reset freq", longint'(freq_out), 64'd850_000_000);
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 strobe drops", longint'(freq_valid), 0);

    // fb=100 od2=2 od1=4 in=2
    write_word(32'h0064_4402);
    check("R2 fb field", longint'(fb_div), 100);
    check("R2 od2 field", longint'(out_div2), 2);
    check("R2 od1 field", longint'(out_div1), 4);
    check("R2 in field", longint'(in_div), 2);
    check("R4 lock set", longint'(rd_data), 64'h8064_4402);
    @(negedge clk);
    check("R6 freq A", longint'(freq_out), 64'd156_250_000);
    check("R9 strobe after write", longint'(freq_valid), 1);

    // power-down, with the lock bit written as 1
    write_word(32'h8064_5402);
    check("R3 pd word", longint'(rd_data), 64'h4064_5402);
    check("R3 pwr_down", longint'(pwr_down), 1);
    @(negedge clk);
    check("R7 unlocked zero", longint'(freq_out), 0);

    write_word(32'h0064_4402);
    check("R4 sticky lost", longint'(lock_lost), 1);
    check("R4 relock", longint'(locked), 1);
    repeat (2) @(negedge clk);
    write_word(32'h4064_4402);
    check("R4 w1c", longint'(lock_lost), 0);
    repeat (4) @(negedge clk);
    check("R5 hold", longint'(rd_data), 64'h8064_4402);

    write_word(32'h0064_4400);
    @(negedge clk);
    check("R8 zero divisor err", longint'(div_err), 1);
    check("R8 zero divisor freq", longint'(freq_out), 0);

    write_word(32'h0064_4402);
    @(negedge clk);
    check("R8 err clears", longint'(div_err), 0);
    ref_freq = 32'd30_000_000;
    @(negedge clk);
    check("R9 ref change strobe", longint'(freq_valid), 1);
    check("R6 new ref", longint'(freq_out), 64'd187_500_000);

    write_word(32'h0FFF_2101);
    @(negedge clk);
    check("R6 wide fb", longint'(freq_out), 64'd122_850_000_000);
    repeat (5) @(negedge clk);
    check("R9 hold after strobe", longint'(freq_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule